// File: doc/BRIEF.md
# Divergent Branch Fork Unit

This block steers a wide SIMD machine through a branch whose condition differs from lane to lane. It keeps the set of lanes that are currently executing as a bit mask, along with the program counter and a small pointer into a stack of deferred paths. A fork request carries a per-lane condition and a branch target. Lanes that are active and have their condition bit set form the taken group. Active lanes with the bit clear form the fall-through group.

When only one group holds active lanes, the block redirects the program counter and does nothing else. When both groups hold active lanes, the block runs the smaller group first and keeps the other group for later. If the two groups are the same size, the taken group runs first. The deferred group's mask and resume address are written as a single entry to an external stack memory through a one-cycle write port, and the pointer then advances. Popping and rejoining the deferred paths is handled elsewhere.

Top module: `fork_unit`

## Requirements
- R1: After reset, `active_mask` equals RESET_MASK (all ones by default), `pc` equals RESET_PC (0x1000 by default), `stk_ptr` is 0, and both `stk_we` and `overflow` are 0.
- R2: If every active lane has its condition bit set, `pc` becomes `target`. The mask and pointer stay unchanged and no stack write occurs.
- R3: If no active lane has its condition bit set, `pc` advances by PC_STEP (4). The mask and pointer stay unchanged and no stack write occurs.
- R4: If the fall-through group has strictly fewer lanes than the taken group, the fall-through group becomes active and `pc` advances by PC_STEP. The pushed entry holds the taken mask and `target`.
- R5: In every other split case, ties included, the taken group becomes active and `pc` becomes `target`. The pushed entry holds the fall-through mask and the old `pc` plus PC_STEP.
- R6: A push raises `stk_we` for exactly one cycle, at the same edge that updates the state. `stk_waddr` is the 32-bit word index, equal to pointer × 4. In `stk_wdata`, bits [63:0] carry the deferred mask (low word first) and bits [127:64] carry the resume address (low word first). The pointer then increments by 1.
- R7: A push requested while the pointer is at its maximum value raises `overflow` for one cycle. No write occurs, and mask, `pc` and pointer all stay unchanged.
- R8: While `fork_req` is low, mask, `pc` and pointer hold their values, and `stk_we` and `overflow` stay 0.
- R9: Condition bits of inactive lanes have no effect on the decision or on the resulting mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fork_req | input | 1 | Perform a fork this cycle |
| cond_mask | input | LANES | Per-lane branch condition |
| target | input | ADDR_W | Branch target address |
| active_mask | output | LANES | Lanes currently executing |
| pc | output | ADDR_W | Program counter |
| stk_ptr | output | SP_W | Deferred-path stack pointer |
| stk_we | output | 1 | Stack entry write strobe |
| stk_waddr | output | SP_W+2 | Word index of the entry written |
| stk_wdata | output | 128 | Entry: mask words, then address words |
| overflow | output | 1 | Push refused because the stack is full |

## Verification
The bench builds the block with SP_W = 2 and keeps the defaults for everything else (64 lanes, 64-bit addresses, 32-bit words, step 4). With 64 lanes, every split that keeps both groups alive at least halves the active set, so the default 3-bit pointer can never fill. The narrower pointer makes the full-stack refusal reachable after three pushes, while a two-lane mask can still split. Each stimulus vector narrows the mask in turn, which puts the all-taken, all-fall-through, smaller-fall-through and tie cases in front of the design, along with condition bits set on inactive lanes.

// File: rtl/fork_pkg.sv
package fork_pkg;

   // Outcome of one fork decision
   typedef enum logic [2:0] {
      FK_NONE      = 3'd0,
      FK_ALL_TAKEN = 3'd1,
      FK_ALL_FALL  = 3'd2,
      FK_RUN_FALL  = 3'd3,
      FK_RUN_TAKEN = 3'd4
   } fork_kind_t;

   function automatic logic kind_pushes(fork_kind_t k);
      return (k == FK_RUN_FALL) || (k == FK_RUN_TAKEN);
   endfunction

endpackage

// File: rtl/lane_popcount.sv
module lane_popcount #(
   parameter  int W     = 64,
   parameter  int CHUNK = 8,
   localparam int CW    = $clog2(W + 1)
) (
   input  logic [W-1:0]  bits,
   output logic [CW-1:0] count
);
   localparam int NCH = W / CHUNK;
   localparam int PW  = $clog2(CHUNK + 1);

   if (W % CHUNK != 0) begin : g_bad_chunk
      $error("lane_popcount: W must be a multiple of CHUNK");
   end

   generate
      if (NCH == 1) begin : g_flat
         always_comb begin
            count = '0;
            for (int i = 0; i < W; i++) count = count + CW'(bits[i]);
         end
      end else begin : g_chunked
         logic [NCH*PW-1:0] parts;
         for (genvar c = 0; c < NCH; c++) begin : g_part
            logic [PW-1:0] cnt;
            always_comb begin
               cnt = '0;
               for (int i = 0; i < CHUNK; i++) cnt = cnt + PW'(bits[c*CHUNK+i]);
            end
            assign parts[c*PW +: PW] = cnt;
         end
         always_comb begin
            count = '0;
            for (int c = 0; c < NCH; c++) count = count + CW'(parts[c*PW +: PW]);
         end
      end
   endgenerate
endmodule

// File: rtl/fork_decide.sv
module fork_decide
   import fork_pkg::*;
#(
   parameter int LANES = 64,
   parameter int CHUNK = 8
) (
   input  logic [LANES-1:0] active,
   input  logic [LANES-1:0] cond,
   output fork_kind_t       kind,
   output logic [LANES-1:0] run_mask,
   output logic [LANES-1:0] defer_mask
);
   localparam int CW = $clog2(LANES + 1);

   logic [LANES-1:0] taken, fall;
   logic [CW-1:0]    n_taken, n_fall;

   assign taken = active & cond;
   assign fall  = active & ~cond;

   lane_popcount #(.W(LANES), .CHUNK(CHUNK)) u_cnt_taken (.bits(taken), .count(n_taken));
   lane_popcount #(.W(LANES), .CHUNK(CHUNK)) u_cnt_fall  (.bits(fall),  .count(n_fall));

   // Uniform outcomes first; the taken side wins any tie
   always_comb begin
      kind       = FK_NONE;
      run_mask   = active;
      defer_mask = '0;
      if (taken == active) begin
         kind = FK_ALL_TAKEN;
      end else if (fall == active) begin
         kind = FK_ALL_FALL;
      end else if (n_fall < n_taken) begin
         kind       = FK_RUN_FALL;
         run_mask   = fall;
         defer_mask = taken;
      end else begin
         kind       = FK_RUN_TAKEN;
         run_mask   = taken;
         defer_mask = fall;
      end
   end
endmodule

// File: rtl/entry_pack.sv
module entry_pack #(
   parameter  int LANES  = 64,
   parameter  int ADDR_W = 64,
   parameter  int WORD_W = 32,
   localparam int MW     = LANES / WORD_W,
   localparam int AW     = ADDR_W / WORD_W,
   localparam int EW     = (MW + AW) * WORD_W
) (
   input  logic [LANES-1:0]  mask,
   input  logic [ADDR_W-1:0] addr,
   output logic [EW-1:0]     data
);
   // Mask words occupy the low words, address words follow
   for (genvar w = 0; w < MW + AW; w++) begin : g_word
      if (w < MW) begin : g_mask
         assign data[w*WORD_W +: WORD_W] = mask[w*WORD_W +: WORD_W];
      end else begin : g_addr
         assign data[w*WORD_W +: WORD_W] = addr[(w-MW)*WORD_W +: WORD_W];
      end
   end
endmodule

// File: rtl/fork_unit.sv
module fork_unit
   import fork_pkg::*;
#(
   parameter  int                LANES      = 64,
   parameter  int                ADDR_W     = 64,
   parameter  int                WORD_W     = 32,
   parameter  int                SP_W       = 3,
   parameter  int                PC_STEP    = 4,
   parameter  int                CHUNK      = 8,
   parameter  logic [LANES-1:0]  RESET_MASK = '1,
   parameter  logic [ADDR_W-1:0] RESET_PC   = ADDR_W'(64'h1000),
   localparam int                ENTRY_WDS  = (LANES + ADDR_W) / WORD_W,
   localparam int                OFF_W      = $clog2(ENTRY_WDS),
   localparam int                ENTRY_W    = ENTRY_WDS * WORD_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  fork_req,
   input  logic [LANES-1:0]      cond_mask,
   input  logic [ADDR_W-1:0]     target,
   output logic [LANES-1:0]      active_mask,
   output logic [ADDR_W-1:0]     pc,
   output logic [SP_W-1:0]       stk_ptr,
   output logic                  stk_we,
   output logic [SP_W+OFF_W-1:0] stk_waddr,
   output logic [ENTRY_W-1:0]    stk_wdata,
   output logic                  overflow
);
   localparam logic [SP_W-1:0] SP_MAX = '1;

   if (LANES % WORD_W != 0) begin : g_bad_lanes
      $error("fork_unit: LANES must be a multiple of WORD_W");
   end
   if (ADDR_W % WORD_W != 0) begin : g_bad_addr
      $error("fork_unit: ADDR_W must be a multiple of WORD_W");
   end
   if ((1 << OFF_W) != ENTRY_WDS) begin : g_bad_entry
      $error("fork_unit: entry word count must be a power of two");
   end
   if (SP_W < 1) begin : g_bad_sp
      $error("fork_unit: SP_W must be at least 1");
   end

   fork_kind_t        kind;
   logic [LANES-1:0]  run_mask, defer_mask;
   logic [ADDR_W-1:0] pc_next_seq, defer_addr;
   logic [ENTRY_W-1:0] entry;

   fork_decide #(.LANES(LANES), .CHUNK(CHUNK)) u_decide (
      .active     (active_mask),
      .cond       (cond_mask),
      .kind       (kind),
      .run_mask   (run_mask),
      .defer_mask (defer_mask)
   );

   assign pc_next_seq = pc + ADDR_W'(PC_STEP);
   assign defer_addr  = (kind == FK_RUN_FALL) ? target : pc_next_seq;

   entry_pack #(.LANES(LANES), .ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_pack (
      .mask (defer_mask),
      .addr (defer_addr),
      .data (entry)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_mask <= RESET_MASK;
         pc          <= RESET_PC;
         stk_ptr     <= '0;
         stk_we      <= 1'b0;
         stk_waddr   <= '0;
         stk_wdata   <= '0;
         overflow    <= 1'b0;
      end else begin
         stk_we   <= 1'b0;
         overflow <= 1'b0;
         if (fork_req) begin
            unique case (kind)
               FK_ALL_TAKEN: pc <= target;
               FK_ALL_FALL:  pc <= pc_next_seq;
               FK_RUN_FALL, FK_RUN_TAKEN: begin
                  if (stk_ptr == SP_MAX) begin
                     overflow <= 1'b1;
                  end else begin
                     active_mask <= run_mask;
                     pc          <= (kind == FK_RUN_FALL) ? pc_next_seq : target;
                     stk_ptr     <= stk_ptr + 1'b1;
                     stk_we      <= 1'b1;
                     stk_waddr   <= {stk_ptr, OFF_W'(0)};
                     stk_wdata   <= entry;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   AST_JUMP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      fork_req && kind == FK_ALL_TAKEN |=> pc == $past(target) && !stk_we && $stable(stk_ptr)); // R2
   AST_STEP_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      fork_req && kind == FK_ALL_FALL |=> pc == $past(pc) + ADDR_W'(PC_STEP) && !stk_we); // R3
   AST_PUSH_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
      stk_we |-> stk_ptr == $past(stk_ptr) + 1'b1); // R6
   AST_WADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      stk_we |-> stk_waddr[OFF_W-1:0] == '0); // R6
   AST_NO_OVERFLOW_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      overflow |-> !stk_we && $stable(stk_ptr) && $stable(pc) && $stable(active_mask)); // R7
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !fork_req |=> $stable(active_mask) && $stable(pc) && $stable(stk_ptr) && !stk_we && !overflow); // R8
   AST_MASK_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
      fork_req |=> (active_mask & ~$past(active_mask)) == '0); // R9
endmodule

// File: tb/fork_unit_bench.sv
module fork_unit_bench;
   localparam int LANES = 64;
   localparam int AW    = 64;
   localparam int SPW   = 2;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic            fork_req = 1'b0;
   logic [LANES-1:0] cond_mask = '0;
   logic [AW-1:0]   target = '0;
   logic [LANES-1:0] active_mask;
   logic [AW-1:0]   pc;
   logic [SPW-1:0]  stk_ptr;
   logic            stk_we;
   logic [SPW+1:0]  stk_waddr;
   logic [127:0]    stk_wdata;
   logic            overflow;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #5 clk = ~clk;

   fork_unit #(.SP_W(SPW)) u_fork_unit (
      .clk(clk), .rst_n(rst_n), .fork_req(fork_req), .cond_mask(cond_mask),
      .target(target), .active_mask(active_mask), .pc(pc), .stk_ptr(stk_ptr),
      .stk_we(stk_we), .stk_waddr(stk_waddr), .stk_wdata(stk_wdata), .overflow(overflow)
   );

   // {condition, target}
   localparam logic [127:0] VECS [0:7] = '{
      {64'hFFFF_FFFF_FFFF_FFFF, 64'h2000},
      {64'h0000_0000_0000_0000, 64'h3000},
      {64'h0000_0000_0000_FFFF, 64'h4000},
      {64'h0000_0000_0000_FFF0, 64'h5000},
      {64'h0000_0000_0000_0003, 64'h6000},
      {64'h0000_0000_0000_0001, 64'h7000},
      {64'hFFFF_FFFF_FFFF_FFFC, 64'h7100},
      {64'h8000_0000_0000_0003, 64'h8000}
   };

   // Reference state
   logic [LANES-1:0] m_mask;
   logic [AW-1:0]    m_pc;
   logic [SPW-1:0]   m_sp;

   task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic int popc(input logic [LANES-1:0] v);
      int n = 0;
      for (int i = 0; i < LANES; i++) n += int'(v[i]);
      return n;
   endfunction

   task automatic check_state(input string tag, input logic exp_we, input logic exp_ovf);
      chk({tag, " mask"}, 128'(active_mask), 128'(m_mask));
      chk({tag, " pc"},   128'(pc), 128'(m_pc));
      chk({tag, " sp"},   128'(stk_ptr), 128'(m_sp));
      chk({tag, " we"},   128'(stk_we), 128'(exp_we));
      chk({tag, " ovf"},  128'(overflow), 128'(exp_ovf));
   endtask

   task automatic do_fork(input logic [63:0] c, input logic [63:0] t, input string extra);
      logic [LANES-1:0] tk, fl, dmask;
      logic [AW-1:0]    daddr;
      logic             push, wexp, oexp;
      string            tag;
      logic [SPW-1:0]   sp_before;
      tk = m_mask & c;
      fl = m_mask & ~c;
      push = 1'b0; dmask = '0; daddr = '0; oexp = 1'b0;
      sp_before = m_sp;
      if (tk == m_mask) begin
         tag = "R2"; m_pc = t;
      end else if (fl == m_mask) begin
         tag = "R3"; m_pc = m_pc + 4;
      end else if (popc(fl) < popc(tk)) begin
         tag = "R4"; push = 1'b1; dmask = tk; daddr = t;
      end else begin
         tag = "R5"; push = 1'b1; dmask = fl; daddr = m_pc + 4;
      end
      if (push) begin
         if (m_sp == '1) begin
            tag = "R7"; oexp = 1'b1;
         end else begin
            if (tag == "R4") m_pc = m_pc + 4; else m_pc = t;
            m_mask = (tag == "R4") ? fl : tk;
            m_sp = m_sp + 1'b1;
         end
      end
      wexp = push && !oexp;
      @(negedge clk);
      fork_req = 1'b1; cond_mask = c; target = t;
      @(negedge clk);
      fork_req = 1'b0;
      check_state({tag, extra}, wexp, oexp);
      if (wexp) begin
         chk("R6 waddr", 128'(stk_waddr), 128'({sp_before, 2'b00}));
         chk("R6 wdata", stk_wdata, {daddr, dmask});
      end
      @(negedge clk);
      chk("R6 single-cycle we", 128'(stk_we), 128'(0));
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      m_mask = '1; m_pc = 64'h1000; m_sp = '0;
      repeat (3) @(negedge clk);
      check_state("R1 in reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      check_state("R1 after reset", 1'b0, 1'b0);

      // R8: idle cycles with a busy condition input
      cond_mask = 64'h1234_5678_9ABC_DEF0; target = 64'hDEAD;
      repeat (3) @(negedge clk);
      check_state("R8 idle", 1'b0, 1'b0);

      for (int i = 0; i < 8; i++) begin
         do_fork(VECS[i][127:64], VECS[i][63:0], (i >= 6) ? " R9" : "");
      end

      // R8: hold after the table, then R1 mid-run reset
      repeat (2) @(negedge clk);
      check_state("R8 idle end", 1'b0, 1'b0);
      rst_n = 1'b0;
      @(negedge clk);
      m_mask = '1; m_pc = 64'h1000; m_sp = '0;
      check_state("R1 re-reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      // Tie from a full mask after reset: R5 into slot 0
      do_fork(64'h0000_0000_FFFF_FFFF, 64'hA000, " tie");

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule